// File: doc/BRIEF.md
# Clock-Activity Reset and Calibration Sequencer

This block watches three externally supplied clocks (a master clock, a bit clock and a frame clock) from a faster, free-running supervisor clock. It drives an internal reset, a one-shot calibration window and a ready flag for the datapath behind it. The datapath stays in reset while the master clock is missing. In slave mode it also stays in reset while no frame clock is arriving. A stall of either clock forces a fresh reset. In slave mode every exit from reset is followed by a calibration window lasting a fixed number of bit-clock periods. In master mode there is no calibration window, the frame clock is ignored and only the master clock matters.

Each raw clock passes through a two-flop synchroniser and a rising-edge detector. Idle timers count the supervisor cycles since each clock's last rising edge. The stall thresholds are set from the nominal master-clock period and the nominal frame period, both given as inputs in supervisor cycles. A three-state sequencer (reset, calibrate, run) turns these conditions into the three outputs.

Top module: `clkmon_seq`

## Requirements
- R1: While `rst_ni` is low, `rst_o` is 1 and `cal_o` and `ready_o` are 0. These values take effect without waiting for a supervisor clock edge.
- R2: When the idle count since the last master-clock rising edge exceeds `STALL_PERIODS` × `mck_period_i` supervisor cycles, `rst_o` asserts and stays high until master-clock edges resume.
- R3: A master-clock stop shorter than the stall threshold (for example 10 periods when `STALL_PERIODS` is 20) leaves the outputs unchanged.
- R4: In slave mode (`slave_i`=1), `rst_o` stays high while the frame clock has no rising edges, even if the master clock is running.
- R5: In slave mode, leaving reset asserts `cal_o`. `cal_o` stays high for exactly `CAL_BITS` detected bit-clock rising edges and then gives way to `ready_o`.
- R6: Once `ready_o` is high, `cal_o` does not assert again until the sequencer has passed back through reset.
- R7: In slave mode, when the idle count since the last frame-clock rising edge exceeds `frame_period_i`, `rst_o` asserts. A new calibration window follows once frame-clock edges return.
- R8: In master mode (`slave_i`=0), leaving reset goes straight to `ready_o` with no calibration window, and frame-clock activity has no effect.
- R9: Exactly one of `rst_o`, `cal_o`, `ready_o` is high at all times. The code {ready_o,cal_o,rst_o} is 3'b001 in reset, 3'b010 during calibration and 3'b100 in run.
- R10: A master-clock stall during the calibration window aborts calibration and returns the block to reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running supervisor clock, faster than all monitored clocks |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| slave_i | input | 1 | 1: slave mode (frame clock checked, calibration used); 0: master mode |
| mck_i | input | 1 | Raw master clock |
| bck_i | input | 1 | Raw bit clock |
| fck_i | input | 1 | Raw frame clock |
| mck_period_i | input | CNT_W | Nominal master-clock period in supervisor cycles |
| frame_period_i | input | CNT_W | Nominal frame period in supervisor cycles |
| rst_o | output | 1 | Datapath reset |
| cal_o | output | 1 | Calibration window active |
| ready_o | output | 1 | Datapath running |

## Verification
The bench builds the block with `CNT_W`=10 and `CAL_BITS`=16, and keeps the default stall multiple of 20. It runs a 4-cycle master clock, an 8-cycle bit clock and a 256-cycle frame. These values put the 80-cycle stall threshold, the 128-cycle calibration window and a multi-frame pause within a few hundred cycles each. That leaves room to test stops just below and just above the threshold, an abort inside the calibration window, and the switch into master mode.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_CAL   = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clkmon_edge.sv
module clkmon_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], raw_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/clkmon_idle.sv
module clkmon_idle #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic [W-1:0] limit_i,
  output logic         absent_o
);
  logic [W-1:0] cnt_q;

  // starts saturated: a clock counts as absent until its first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '1;
    else if (rise_i)        cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign absent_o = cnt_q > limit_i;
endmodule

// File: rtl/clkmon_fsm.sv
module clkmon_fsm
  import clkmon_pkg::*;
#(
  parameter int CAL_BITS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic mck_absent_i,
  input  logic fck_absent_i,
  input  logic bck_rise_i,
  output logic rst_o,
  output logic cal_o,
  output logic ready_o
);
  localparam int CAL_W = $clog2(CAL_BITS + 1);

  seq_state_e       state_q, state_d;
  logic [CAL_W-1:0] cal_cnt_q;
  logic             clocks_ok;

  assign clocks_ok = !mck_absent_i && (!slave_i || !fck_absent_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET: if (clocks_ok) state_d = slave_i ? ST_CAL : ST_RUN;
      ST_CAL: begin
        if (!clocks_ok)
          state_d = ST_RESET;
        else if (bck_rise_i && cal_cnt_q == CAL_W'(CAL_BITS - 1))
          state_d = ST_RUN;
      end
      ST_RUN:   if (!clocks_ok) state_d = ST_RESET;
      default:  state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      cal_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_CAL)  cal_cnt_q <= '0;
      else if (bck_rise_i)    cal_cnt_q <= cal_cnt_q + 1'b1;
    end
  end

  assign rst_o   = state_q == ST_RESET;
  assign cal_o   = state_q == ST_CAL;
  assign ready_o = state_q == ST_RUN;
endmodule

// File: rtl/clkmon_seq.sv
module clkmon_seq #(
  parameter int CNT_W         = 16,
  parameter int STALL_PERIODS = 20,
  parameter int CAL_BITS      = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             mck_i,
  input  logic             bck_i,
  input  logic             fck_i,
  input  logic [CNT_W-1:0] mck_period_i,
  input  logic [CNT_W-1:0] frame_period_i,
  output logic             rst_o,
  output logic             cal_o,
  output logic             ready_o
);
  localparam int LIM_W = CNT_W + $clog2(STALL_PERIODS + 1);
  localparam int N_CLK = 3;

  logic [N_CLK-1:0] raw, rise;
  logic             mck_absent, fck_absent, bck_rise;
  logic [LIM_W-1:0] stall_lim;

  assign raw = {fck_i, bck_i, mck_i};

  for (genvar g = 0; g < N_CLK; g++) begin : g_sync
    clkmon_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .rise_o (rise[g])
    );
  end

  assign bck_rise  = rise[1];
  assign stall_lim = LIM_W'(mck_period_i) * LIM_W'(STALL_PERIODS);

  clkmon_idle #(.W(LIM_W)) u_mck_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise[0]),
    .limit_i  (stall_lim),
    .absent_o (mck_absent)
  );

  clkmon_idle #(.W(CNT_W)) u_fck_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise[2]),
    .limit_i  (frame_period_i),
    .absent_o (fck_absent)
  );

  clkmon_fsm #(.CAL_BITS(CAL_BITS)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slave_i      (slave_i),
    .mck_absent_i (mck_absent),
    .fck_absent_i (fck_absent),
    .bck_rise_i   (bck_rise),
    .rst_o        (rst_o),
    .cal_o        (cal_o),
    .ready_o      (ready_o)
  );
endmodule

// File: rtl/clkmon_seq_chk.sv
module clkmon_seq_chk #(
  parameter int CAL_BITS = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic slave_i,
  input logic rst_o,
  input logic cal_o,
  input logic ready_o,
  input logic mck_absent,
  input logic fck_absent,
  input logic bck_rise
);
  localparam int CAL_W = $clog2(CAL_BITS + 1);
  logic [CAL_W-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       n_q <= '0;
    else if (!cal_o)   n_q <= '0;
    else if (bck_rise) n_q <= n_q + 1'b1;
  end

  a_r1_reset_vals: assert property (@(posedge clk_i) !rst_ni |-> rst_o && !cal_o && !ready_o);
  a_r9_onehot:     assert property (@(posedge clk_i) disable iff (!rst_ni) $countones({rst_o, cal_o, ready_o}) == 1);
  a_r2_stall:      assert property (@(posedge clk_i) disable iff (!rst_ni) mck_absent |=> rst_o);
  a_r7_pause:      assert property (@(posedge clk_i) disable iff (!rst_ni) slave_i && fck_absent |=> rst_o);
  a_r8_cal_slave:  assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cal_o) |-> $past(slave_i) && $past(rst_o));
  a_r5_cal_len:    assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(cal_o) && ready_o |-> n_q == CAL_W'(CAL_BITS));
  a_r6_no_recal:   assert property (@(posedge clk_i) disable iff (!rst_ni) ready_o |=> !cal_o);
endmodule

bind clkmon_seq clkmon_seq_chk #(.CAL_BITS(CAL_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slave_i    (slave_i),
  .rst_o      (rst_o),
  .cal_o      (cal_o),
  .ready_o    (ready_o),
  .mck_absent (mck_absent),
  .fck_absent (fck_absent),
  .bck_rise   (bck_rise)
);

// File: tb/tb_clkmon_seq.sv
`timescale 1ns/1ps
module tb_clkmon_seq;
  localparam int CNT_W = 10;
  localparam int CAL_BITS = 16;
  localparam logic [2:0] C_RST = 3'b001, C_CAL = 3'b010, C_RUN = 3'b100;

  logic clk = 0, rst_ni = 0, slave = 1;
  logic mck_en = 1, bck_en = 1, fck_en = 0;
  logic [15:0] cyc = '0;
  logic rst_o, cal_o, ready_o;
  int checks = 0, errors = 0;
  logic [2:0] exp_q[$];
  logic [2:0] last = C_RST;
  int cal_start = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1'b1;

  clkmon_seq #(.CNT_W(CNT_W), .CAL_BITS(CAL_BITS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .slave_i(slave),
    .mck_i(mck_en & cyc[1]), .bck_i(bck_en & cyc[2]), .fck_i(fck_en & cyc[7]),
    .mck_period_i(10'd4), .frame_period_i(10'd256),
    .rst_o(rst_o), .cal_o(cal_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c);
    exp_q.push_back(c);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every output change must match the next expected code
  always @(negedge clk) begin
    logic [2:0] cur;
    cur = {ready_o, cal_o, rst_o};
    if (cur != last) begin
      if (exp_q.size() == 0) chk(0, "R6/R9 unexpected change", cur, last);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk(cur == e, "R9 state sequence", cur, e);
      end
      if (cur == C_CAL) cal_start = cyc;
      if (last == C_CAL && cur == C_RUN)
        chk((cyc - cal_start) >= CAL_BITS*8 - 8 && (cyc - cal_start) <= CAL_BITS*8 + 8,
            "R5 calibration length", cyc - cal_start, CAL_BITS*8);
      last = cur;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0;
    wait_n(5);
    chk({ready_o, cal_o, rst_o} == C_RST, "R1 reset state", {ready_o, cal_o, rst_o}, C_RST);
    rst_ni = 1;
    wait_n(300);
    chk(rst_o == 1, "R4 held without frame clock", rst_o, 1);

    push(C_CAL); push(C_RUN);
    fck_en = 1;
    wait_n(700);
    chk(ready_o == 1, "R5 ready after calibration", ready_o, 1);
    wait_n(500);
    chk(ready_o == 1 && exp_q.size() == 0, "R6 no recalibration", ready_o, 1);

    mck_en = 0; wait_n(40); mck_en = 1; wait_n(50);
    chk(ready_o == 1, "R3 short stop ignored", ready_o, 1);

    push(C_RST);
    mck_en = 0; t0 = cyc;
    for (int i = 0; i < 500 && !rst_o; i++) @(negedge clk);
    chk(cyc - t0 >= 75 && cyc - t0 <= 92, "R2 stall detect delay", cyc - t0, 82);
    wait_n(200);
    chk(rst_o == 1, "R2 held while stalled", rst_o, 1);
    push(C_CAL); push(C_RUN);
    mck_en = 1; wait_n(700);
    chk(ready_o == 1, "R2 recovers after stall", ready_o, 1);

    push(C_RST); push(C_CAL); push(C_RUN);
    fck_en = 0; wait_n(700);
    chk(rst_o == 1, "R7 frame pause resets", rst_o, 1);
    fck_en = 1; wait_n(700);
    chk(ready_o == 1 && exp_q.size() == 0, "R7 recalibrated", ready_o, 1);

    push(C_RST); push(C_CAL); push(C_RST);
    fck_en = 0;
    for (int i = 0; i < 2000 && !rst_o; i++) @(negedge clk);
    fck_en = 1;
    for (int i = 0; i < 2000 && !cal_o; i++) @(negedge clk);
    wait_n(20);
    mck_en = 0;
    for (int i = 0; i < 500 && !rst_o; i++) @(negedge clk);
    chk(rst_o == 1, "R10 stall aborts calibration", rst_o, 1);
    push(C_CAL); push(C_RUN);
    mck_en = 1; wait_n(700);
    chk(ready_o == 1, "R10 recovers", ready_o, 1);

    push(C_RST);
    rst_ni = 0; #1;
    chk(rst_o == 1 && !ready_o, "R1 async reset", rst_o, 1);
    wait_n(3);
    slave = 0; fck_en = 0;
    push(C_RUN);
    rst_ni = 1; wait_n(300);
    chk(ready_o == 1, "R8 master runs without frame clock", ready_o, 1);
    fck_en = 1; wait_n(300); fck_en = 0; wait_n(600);
    chk(ready_o == 1, "R8 frame clock ignored", ready_o, 1);

    push(C_RST); push(C_RUN);
    mck_en = 0; wait_n(200);
    chk(rst_o == 1, "R2 master stall resets", rst_o, 1);
    mck_en = 1; wait_n(100);
    chk(ready_o == 1, "R8 master no calibration", ready_o, 1);
    chk(exp_q.size() == 0, "R9 all transitions seen", exp_q.size(), 0);
    finish_run();
  end
endmodule